// File: doc/BRIEF.md
# Ternary Match Array with Write Guard

This block is a small ternary content-addressable match array. Every row keeps two bit-planes, a value plane and a qualifier plane, for each of three words: an interface-tag word and two key words. Together the two planes tell each key bit to match a 0, to match a 1, or to ignore the key. One logical entry covers `SPAN` consecutive banks, and it hits only when its row matches in every bank it covers. Each entry also has an enable bit, which is written separately from the planes.

Configuration uses a register-style write port. Each write loads one word of one plane in one bank row. If a write would leave both planes set in any bit position, the write is dropped in full and the stored word keeps its old value. To reload an entry safely, software disables the entry, writes zero to the value plane and then to the qualifier plane, writes the new contents, and enables the entry again.

A small tracker state machine holds the outcome of the most recent write. It has three states. `WT_NONE` is the state after reset. A write that is stored moves the tracker to `WT_TAKEN`, and a dropped write moves it to `WT_DROPPED`. When no write is presented, the tracker stays in its current state. The `wr_dropped` output is high only in `WT_DROPPED`.

On the lookup side, a key and a tag are presented with `lk_valid`. The flag `lk_hit` and the index of the lowest-numbered matching enabled entry appear one clock later.

Top module: `tcam_guarded`

## Requirements
- R1: Per bit, the value/qualifier pair (0,1) matches only a key bit of 0, the pair (1,0) matches only a key bit of 1, and the pair (0,0) matches either value.
- R2: A write to one plane is dropped in full when the written data, ANDed with the other plane's current word, is non-zero. The stored word is then unchanged and `wr_dropped` is high after the write's clock edge.
- R3: Writing zero to the value plane and then zero to the qualifier plane of a word is always accepted. It leaves the word as all don't-care, after which any new value can be loaded.
- R4: `wr_field` selects the word: 0 is the tag word, whose low `TAGW` bits are compared with `lk_tag` in every bank; 1 is key word 0; 2 is key word 1. Each word exists in both planes. The tag word is subject to the same guard as the key words.
- R5: Entry e uses row e mod `ROWS` in banks (e div `ROWS`)·`SPAN` and upward, `SPAN` banks in all. Bank slot s compares key word 0 with `lk_key[s*2*KW +: KW]` and key word 1 with the next `KW` bits. All covered banks must match for the entry to hit.
- R6: A disabled entry never hits, whatever its planes hold. Toggling the enable bit leaves the planes unchanged.
- R7: When several enabled entries match, `lk_index` reports the lowest-numbered one.
- R8: `lk_hit` and `lk_index` are registered and reflect the lookup presented one clock earlier. A cycle without `lk_valid` gives `lk_hit` = 0 one clock later.
- R9: After reset, every plane word is zero, every entry is disabled and `wr_dropped` is low.
- R10: `wr_dropped` reports the outcome of the most recent write: high if that write was dropped, low if it was stored. It holds its value through cycles with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Plane write strobe |
| wr_bank | input | BW | Target bank |
| wr_row | input | RW | Target row within the bank |
| wr_plane | input | 1 | 1 = value plane, 0 = qualifier plane |
| wr_field | input | 2 | 0 tag, 1 key word 0, 2 key word 1 (3 stores nothing) |
| wr_data | input | KW | Write data |
| en_we | input | 1 | Entry enable write strobe |
| en_index | input | IW | Entry whose enable is written |
| en_val | input | 1 | New enable value |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | SPAN*2*KW | Search key |
| lk_tag | input | TAGW | Interface tag for the lookup |
| lk_hit | output | 1 | Registered hit flag |
| lk_index | output | IW | Registered winning entry (0 on miss) |
| wr_dropped | output | 1 | Most recent plane write was dropped |

## Verification
The hardest case to reach from the ports is a dropped write that must leave an already programmed word exactly as it was. This can only be seen through later lookups. The stimulus first builds an exact-match pattern across both banks of an entry. It then attempts conflicting writes to each plane and to the tag word. After each attempt it repeats lookups that hit only if the old word is intact and that would miss if the new data had been stored. The same sequence then walks the clear-and-reload order and checks that each of its steps is accepted.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [1:0] {
        WT_NONE    = 2'd0,
        WT_TAKEN   = 2'd1,
        WT_DROPPED = 2'd2
    } wr_trk_e;

    localparam logic [1:0] FLD_TAG = 2'd0;
    localparam logic [1:0] FLD_W0  = 2'd1;
    localparam logic [1:0] FLD_W1  = 2'd2;
    localparam logic [1:0] FLD_NONE = 2'd3;
endpackage

// File: rtl/tcam_bank_store.sv
module tcam_bank_store
    import tcam_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int KW   = 8,
    parameter int TAGW = 2,
    parameter int RW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_sel,
    input  logic [RW-1:0]   wr_row,
    input  logic            wr_plane,
    input  logic [1:0]      wr_field,
    input  logic [KW-1:0]   wr_data,
    output logic            wr_conflict,
    input  logic [KW-1:0]   key_w0,
    input  logic [KW-1:0]   key_w1,
    input  logic [TAGW-1:0] key_tag,
    output logic [ROWS-1:0] row_hit
);
    // plane_q[plane][word][row]; plane 1 = value, plane 0 = qualifier
    logic [KW-1:0] plane_q [2][3][ROWS];

    logic [1:0]    fidx;
    logic          field_ok;
    logic [KW-1:0] tag_mask;
    logic [KW-1:0] wdat;
    logic [KW-1:0] opposite;

    assign field_ok = (wr_field != FLD_NONE);
    assign fidx     = field_ok ? wr_field : FLD_TAG;
    assign tag_mask = {{(KW-TAGW){1'b0}}, {TAGW{1'b1}}};
    assign wdat     = (wr_field == FLD_TAG) ? (wr_data & tag_mask) : wr_data;
    assign opposite = plane_q[~wr_plane][fidx][wr_row];

    // Guard: any bit that would end up set in both planes rejects the write
    assign wr_conflict = wr_sel & field_ok & (|(wdat & opposite));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++)
                for (int f = 0; f < 3; f++)
                    for (int r = 0; r < ROWS; r++)
                        plane_q[p][f][r] <= '0;
        end else if (wr_sel && field_ok && !wr_conflict) begin
            plane_q[wr_plane][fidx][wr_row] <= wdat;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic tag_bad, w0_bad, w1_bad;
        assign tag_bad = |((plane_q[1][FLD_TAG][r][TAGW-1:0] & ~key_tag) |
                           (plane_q[0][FLD_TAG][r][TAGW-1:0] &  key_tag));
        assign w0_bad  = |((plane_q[1][FLD_W0][r] & ~key_w0) |
                           (plane_q[0][FLD_W0][r] &  key_w0));
        assign w1_bad  = |((plane_q[1][FLD_W1][r] & ~key_w1) |
                           (plane_q[0][FLD_W1][r] &  key_w1));
        assign row_hit[r] = ~(tag_bad | w0_bad | w1_bad);
    end
endmodule

// File: rtl/tcam_first_set.sv
module tcam_first_set #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_wr_tracker.sv
module tcam_wr_tracker
    import tcam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_reject,
    output logic wr_dropped
);
    wr_trk_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WT_NONE, WT_TAKEN, WT_DROPPED: begin
                if (wr_en) state_d = wr_reject ? WT_DROPPED : WT_TAKEN;
            end
            default: state_d = WT_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WT_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            WT_DROPPED: wr_dropped = 1'b1;
            WT_NONE,
            WT_TAKEN:   wr_dropped = 1'b0;
            default:    wr_dropped = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcam_guarded.sv
module tcam_guarded
    import tcam_pkg::*;
#(
    parameter int NBANK = 2,
    parameter int ROWS  = 4,
    parameter int SPAN  = 2,
    parameter int KW    = 8,
    parameter int TAGW  = 2,
    localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int NENT = ROWS * (NBANK / SPAN),
    localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
    localparam int KEYW = SPAN * 2 * KW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BW-1:0]   wr_bank,
    input  logic [RW-1:0]   wr_row,
    input  logic            wr_plane,
    input  logic [1:0]      wr_field,
    input  logic [KW-1:0]   wr_data,
    input  logic            en_we,
    input  logic [IW-1:0]   en_index,
    input  logic            en_val,
    input  logic            lk_valid,
    input  logic [KEYW-1:0] lk_key,
    input  logic [TAGW-1:0] lk_tag,
    output logic            lk_hit,
    output logic [IW-1:0]   lk_index,
    output logic            wr_dropped
);
    logic [ROWS-1:0]  bank_hit [NBANK];
    logic [NBANK-1:0] bank_conf;
    logic             wr_reject;
    logic [NENT-1:0]  ent_en;
    logic [NENT-1:0]  ent_match;
    logic             any_match;
    logic [IW-1:0]    win_idx;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int SLOT = b % SPAN;
        tcam_bank_store #(.ROWS(ROWS), .KW(KW), .TAGW(TAGW), .RW(RW)) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_sel     (wr_en && (wr_bank == BW'(b))),
            .wr_row     (wr_row),
            .wr_plane   (wr_plane),
            .wr_field   (wr_field),
            .wr_data    (wr_data),
            .wr_conflict(bank_conf[b]),
            .key_w0     (lk_key[SLOT*2*KW +: KW]),
            .key_w1     (lk_key[(SLOT*2+1)*KW +: KW]),
            .key_tag    (lk_tag),
            .row_hit    (bank_hit[b])
        );
    end

    assign wr_reject = |bank_conf;

    // An entry hits only when its row hits in every bank it spans
    for (genvar e = 0; e < NENT; e++) begin : g_ent
        localparam int GRP = e / ROWS;
        localparam int ROW = e % ROWS;
        logic [SPAN-1:0] slot_hit;
        for (genvar s = 0; s < SPAN; s++) begin : g_slot
            assign slot_hit[s] = bank_hit[GRP*SPAN + s][ROW];
        end
        assign ent_match[e] = ent_en[e] & (&slot_hit);
    end

    tcam_first_set #(.N(NENT), .IW(IW)) pick_i (
        .vec  (ent_match),
        .found(any_match),
        .idx  (win_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_en <= '0;
        end else if (en_we) begin
            ent_en[en_index] <= en_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit   <= 1'b0;
            lk_index <= '0;
        end else begin
            lk_hit   <= lk_valid & any_match;
            lk_index <= (lk_valid & any_match) ? win_idx : '0;
        end
    end

    tcam_wr_tracker trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_reject (wr_reject),
        .wr_dropped(wr_dropped)
    );
endmodule

// File: rtl/tcam_guard_chk.sv
module tcam_guard_chk #(
    parameter int NENT = 4,
    parameter int IW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_reject,
    input logic            wr_dropped,
    input logic            lk_valid,
    input logic            lk_hit,
    input logic [IW-1:0]   lk_index,
    input logic [NENT-1:0] ent_en
);
    logic [NENT-1:0] ent_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ent_en_q <= '0;
        else        ent_en_q <= ent_en;
    end

    assert_drop_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_dropped == $past(wr_reject)));

    assert_drop_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_dropped));

    assert_idle_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !lk_hit);

    assert_hit_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ent_en_q[lk_index]);

    assert_miss_index_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_index == '0));
endmodule

bind tcam_guarded tcam_guard_chk #(.NENT(NENT), .IW(IW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_reject (wr_reject),
    .wr_dropped(wr_dropped),
    .lk_valid  (lk_valid),
    .lk_hit    (lk_hit),
    .lk_index  (lk_index),
    .ent_en    (ent_en)
);

// File: tb/tcam_guarded_tb_top.sv
`timescale 1ns/1ps
module tcam_guarded_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_bank = '0;
    logic [1:0]  wr_row = '0;
    logic        wr_plane = 1'b0;
    logic [1:0]  wr_field = '0;
    logic [7:0]  wr_data = '0;
    logic        en_we = 1'b0;
    logic [1:0]  en_index = '0;
    logic        en_val = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_key = '0;
    logic [1:0]  lk_tag = '0;
    logic        lk_hit;
    logic [1:0]  lk_index;
    logic        wr_dropped;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic  hit;
        logic [1:0] idx;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    tcam_guarded dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_row(wr_row), .wr_plane(wr_plane),
        .wr_field(wr_field), .wr_data(wr_data),
        .en_we(en_we), .en_index(en_index), .en_val(en_val),
        .lk_valid(lk_valid), .lk_key(lk_key), .lk_tag(lk_tag),
        .lk_hit(lk_hit), .lk_index(lk_index), .wr_dropped(wr_dropped)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard items as lookup results appear
    always @(posedge clk) begin
        if (lk_valid) begin
            #1;
            if (sb_q.size() == 0) begin
                check(0, "scoreboard-empty", 0, 1);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(lk_hit == it.hit, it.req, lk_hit, it.hit);
                if (it.hit)
                    check(lk_index == it.idx, it.req, lk_index, it.idx);
            end
        end
    end

    task automatic do_wr(input logic bank, input logic [1:0] row, input logic plane,
                         input logic [1:0] fld, input logic [7:0] data,
                         input logic exp_drop, input string req);
        @(negedge clk);
        wr_en = 1; wr_bank = bank; wr_row = row; wr_plane = plane;
        wr_field = fld; wr_data = data;
        @(negedge clk);
        wr_en = 0;
        check(wr_dropped == exp_drop, req, wr_dropped, exp_drop);
    endtask

    task automatic set_en(input logic [1:0] idx, input logic val);
        @(negedge clk);
        en_we = 1; en_index = idx; en_val = val;
        @(negedge clk);
        en_we = 0;
    endtask

    // key layout: {bank1 w1, bank1 w0, bank0 w1, bank0 w0}
    task automatic look(input logic [7:0] b0w0, input logic [7:0] b1w1,
                        input logic [1:0] tag, input logic eh,
                        input logic [1:0] ei, input string req);
        exp_t it;
        @(negedge clk);
        lk_valid = 1; lk_key = {b1w1, 8'h5C, 8'h3D, b0w0}; lk_tag = tag;
        it.hit = eh; it.idx = ei; it.req = req;
        sb_q.push_back(it);
        @(negedge clk);
        lk_valid = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(wr_dropped == 0, "R9 reset wr_dropped", wr_dropped, 0);
        check(lk_hit == 0, "R9 reset lk_hit", lk_hit, 0);
        look(8'h00, 8'h00, 2'd0, 0, 0, "R9 all disabled after reset");

        // zero planes are all don't-care; lowest enabled wins
        for (int i = 0; i < 4; i++) set_en(2'(i), 1);
        look(8'h77, 8'h11, 2'd3, 1, 0, "R7 lowest of all-dont-care");
        set_en(0, 0);
        look(8'h77, 8'h11, 2'd3, 1, 1, "R6 R7 entry0 disabled");
        set_en(1, 0); set_en(2, 0); set_en(3, 0);
        look(8'h77, 8'h11, 2'd3, 0, 0, "R6 all disabled");

        // program entry 2: bank0 w0 exact A5, bank1 w1 low nibble ones
        do_wr(0, 2, 1, 2'd1, 8'hA5, 0, "R1 value plane load");
        do_wr(0, 2, 0, 2'd1, 8'h5A, 0, "R1 qualifier plane load");
        do_wr(1, 2, 1, 2'd2, 8'h0F, 0, "R5 bank1 word1 load");
        set_en(2, 1);
        look(8'hA5, 8'h3F, 2'd0, 1, 2, "R1 R5 exact hit");
        look(8'hA4, 8'h3F, 2'd0, 0, 0, "R1 one bit differs");
        look(8'hA5, 8'h3E, 2'd0, 0, 0, "R5 second bank mismatch");
        look(8'hA5, 8'hFF, 2'd1, 1, 2, "R1 dont-care upper nibble");

        // reserved combination attempts
        do_wr(0, 2, 0, 2'd1, 8'h01, 1, "R2 qualifier overlap dropped");
        look(8'hA5, 8'h3F, 2'd0, 1, 2, "R2 word unchanged after drop");
        check(wr_dropped == 1, "R10 holds across lookup", wr_dropped, 1);
        do_wr(0, 2, 1, 2'd1, 8'hFF, 1, "R2 value overlap dropped");
        look(8'hA5, 8'h3F, 2'd0, 1, 2, "R2 value word unchanged");
        do_wr(1, 2, 0, 2'd1, 8'h00, 0, "R10 accepted write clears flag");

        // tag word: must equal 2
        do_wr(0, 2, 1, 2'd0, 8'h02, 0, "R4 tag value load");
        do_wr(0, 2, 0, 2'd0, 8'h01, 0, "R4 tag qualifier load");
        look(8'hA5, 8'h3F, 2'd2, 1, 2, "R4 tag match");
        look(8'hA5, 8'h3F, 2'd1, 0, 0, "R4 tag mismatch 1");
        look(8'hA5, 8'h3F, 2'd3, 0, 0, "R4 tag mismatch 3");
        do_wr(0, 2, 1, 2'd0, 8'h03, 1, "R4 R2 tag overlap dropped");
        look(8'hA5, 8'h3F, 2'd2, 1, 2, "R4 tag unchanged");

        // enable independent of content
        set_en(2, 0);
        look(8'hA5, 8'h3F, 2'd2, 0, 0, "R6 disabled no hit");
        set_en(2, 1);
        look(8'hA5, 8'h3F, 2'd2, 1, 2, "R6 re-enabled contents kept");

        // clear then reload word 0
        do_wr(0, 2, 1, 2'd1, 8'h00, 0, "R3 clear value plane");
        do_wr(0, 2, 0, 2'd1, 8'h00, 0, "R3 clear qualifier plane");
        look(8'h13, 8'h3F, 2'd2, 1, 2, "R3 cleared word dont-care");
        do_wr(0, 2, 0, 2'd1, 8'hFF, 0, "R3 reload after clear");
        look(8'h00, 8'h3F, 2'd2, 1, 2, "R3 reload exact zero hit");
        look(8'h01, 8'h3F, 2'd2, 0, 0, "R3 reload mismatch");

        // priority between two matching entries
        set_en(1, 1);
        look(8'h00, 8'h3F, 2'd2, 1, 1, "R7 lower entry wins");
        set_en(1, 0);
        look(8'h00, 8'h3F, 2'd2, 1, 2, "R7 higher entry alone");

        // registered output drops after idle cycle
        @(negedge clk);
        check(lk_hit == 0, "R8 idle cycle no hit", lk_hit, 0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R8 scoreboard drained", sb_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule